// File: doc/BRIEF.md
# RGB-to-YUV output color matrix

This block sits at the end of a display pipeline and turns a stream of 8-bit-per-channel RGB pixels into YUV. Each output channel is a weighted sum of the three input channels plus a per-channel offset. The weights come from a bank of twelve programmable coefficient words, arranged as three rows of four. A one-bit enable selects between conversion and a pure pass-through. The enable takes hold only when a new frame starts, so a single frame never mixes the two modes.

Pixels enter and leave on valid/ready streams. A start-of-frame flag and an end-of-line flag travel alongside each pixel. The datapath has three register stages, and the whole pipeline stalls together when the downstream sink holds off. A simple write-only register port loads the coefficient words and the enable. Reset loads a default set of coefficients that produces studio-range YUV.

Top module: `rgb2yuv_csc`

## Requirements
- R1: After reset the output stream is empty, `in_ready` is high and conversion is off. The coefficient words take their default values: Y row 0x107, 0x204, 0x064, offset 0x108; U row 0x3F69, 0x3ED6, 0x1C1, offset 0x808; V row 0x1C1, 0x3E88, 0x3FB8, offset 0x808.
- R2: Coefficient index i sits at register address i, for i from 0 to 11. Index 4*row+col holds the R (col 0), G (col 1) or B (col 2) multiplier or the offset (col 3), with rows Y, U and V numbered 0, 1 and 2. `in_data` packs R, G and B in bits [23:16], [15:8] and [7:0]. `out_data` packs Y, U and V in the same bit ranges.
- R3: Multiplier words are 14-bit two's complement values with 10 fractional bits, so 0x400 means 1.0 and 0x3F69 is negative.
- R4: Offset words are unsigned, with 4 fractional bits (0x010 means 1.0).
- R5: Each output channel equals floor(S + 0.5) clamped to 0..255. S is the exact sum of the three products plus the offset, so halves round upward.
- R6: Address 12, bit 0 is the conversion enable. While conversion is off, `out_data` equals the input pixel unchanged.
- R7: A write to the enable changes the mode only from the next accepted pixel that carries `in_sof`. Pixels between the write and that pixel keep the previous mode.
- R8: With no stall, a pixel accepted in cycle n appears on the output in cycle n+3 together with its own `sof` and `eol` flags. Pixels leave in the order they were accepted, and none is lost or duplicated.
- R9: While `out_valid` is high and `out_ready` is low, the output data and flags hold steady and `in_ready` is low.
- R10: Writes to addresses 13 to 15 change neither the coefficients nor the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: 0-11 coefficients, 12 control |
| reg_wdata | input | 14 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_data | input | 24 | Input pixel {R,G,B} |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_eol | input | 1 | Input pixel is the last of a line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink takes the output pixel |
| out_data | output | 24 | Output pixel {Y,U,V} or bypassed {R,G,B} |
| out_sof | output | 1 | Delayed start-of-frame flag |
| out_eol | output | 1 | Delayed end-of-line flag |

## Verification
The assertions check the stream behaviour on every cycle:
- the output and flags hold during a stall, and the input refuses pixels while the output is stuck;
- an accepted pixel and its start-of-frame flag reach the output after three unstalled cycles;
- in pass-through mode the output carries the delayed input word;
- the frame mode moves only on an accepted start-of-frame pixel;
- writes to unused addresses leave the coefficient bank alone.

The numeric results can only be shown by the bench's scenarios, which compare every output pixel with an independent model. These results cover the default matrix, negative weights, offset scaling, clamping at both ends and round-half-up ties. A mid-frame enable change is checked to wait for the next frame.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int PIX_W     = 8;
  localparam int COEF_W    = 14;
  localparam int COEF_FRAC = 10;
  localparam int OFF_FRAC  = 4;
  localparam int NUM_COEF  = 12;
  localparam int CTRL_IDX  = 12;
  localparam int PROD_W    = COEF_W + PIX_W + 1;
  localparam int ACC_W     = PROD_W + 3;

  // Reset value of coefficient word idx (row-major: Y, U, V; R, G, B, offset)
  function automatic logic [COEF_W-1:0] default_coef(input int idx);
    case (idx)
      0:  return 14'h0107;
      1:  return 14'h0204;
      2:  return 14'h0064;
      3:  return 14'h0108;
      4:  return 14'h3F69;
      5:  return 14'h3ED6;
      6:  return 14'h01C1;
      7:  return 14'h0808;
      8:  return 14'h01C1;
      9:  return 14'h3E88;
      10: return 14'h3FB8;
      default: return 14'h0808;
    endcase
  endfunction

  // Signed weight times unsigned channel value
  function automatic logic signed [PROD_W-1:0] csc_mul(input logic [COEF_W-1:0] c,
                                                        input logic [PIX_W-1:0] p);
    logic signed [PROD_W-1:0] cw, pw;
    cw = PROD_W'($signed(c));
    pw = $signed({{(PROD_W-PIX_W){1'b0}}, p});
    return cw * pw;
  endfunction

  // Offset word moved onto the product scale
  function automatic logic signed [ACC_W-1:0] csc_offset(input logic [COEF_W-1:0] o);
    return $signed({{(ACC_W-COEF_W-(COEF_FRAC-OFF_FRAC)){1'b0}}, o,
                    {(COEF_FRAC-OFF_FRAC){1'b0}}});
  endfunction

  // Round half up, then saturate to the channel range
  function automatic logic [PIX_W-1:0] csc_round_clamp(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] t;
    t = acc + ACC_W'(1 << (COEF_FRAC-1));
    t = t >>> COEF_FRAC;
    if (t < 0) return '0;
    if (t > ACC_W'((1 << PIX_W) - 1)) return '1;
    return t[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
  import csc_pkg::*;
#(
  parameter int NCOEF = NUM_COEF,
  parameter int CW    = COEF_W,
  parameter int AW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [AW-1:0]       reg_addr,
  input  logic [CW-1:0]       reg_wdata,
  output logic [NCOEF*CW-1:0] coef_flat,
  output logic                conv_en_cfg
);
  for (genvar i = 0; i < NCOEF; i++) begin : g_word
    logic [CW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= CW'(default_coef(i));
      else if (reg_wr && reg_addr == AW'(i))
        word_q <= reg_wdata;
    end
    assign coef_flat[i*CW +: CW] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      conv_en_cfg <= 1'b0;
    else if (reg_wr && reg_addr == AW'(CTRL_IDX))
      conv_en_cfg <= reg_wdata[0];
  end
endmodule

// File: rtl/csc_frame_mode.sv
module csc_frame_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic sof,
  input  logic en_cfg,
  output logic px_mode,
  output logic frame_mode
);
  // A start-of-frame pixel picks up the programmed enable; others follow the frame
  assign px_mode = sof ? en_cfg : frame_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      frame_mode <= 1'b0;
    else if (accept)
      frame_mode <= px_mode;
  end
endmodule

// File: rtl/csc_row.sv
module csc_row
  import csc_pkg::*;
#(
  parameter int PW = PIX_W,
  parameter int CW = COEF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [3*PW-1:0] pix,
  input  logic [4*CW-1:0] coefs,
  input  logic [PW-1:0]   pass_val,
  input  logic            mode,
  output logic [PW-1:0]   res
);
  logic signed [PROD_W-1:0] prod_q [3];
  logic [CW-1:0]            off_q;
  logic [PW-1:0]            byp1_q, byp2_q;
  logic                     mode1_q, mode2_q;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [ACC_W-1:0]  sum_d;

  always_comb begin
    sum_d = csc_offset(off_q);
    for (int k = 0; k < 3; k++)
      sum_d = sum_d + ACC_W'(prod_q[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) prod_q[k] <= '0;
      off_q   <= '0;
      byp1_q  <= '0;
      byp2_q  <= '0;
      mode1_q <= 1'b0;
      mode2_q <= 1'b0;
      acc_q   <= '0;
      res     <= '0;
    end else if (adv) begin
      // stage 1: products, channel k of the row multiplies field (2-k) of the pixel
      for (int k = 0; k < 3; k++)
        prod_q[k] <= csc_mul(coefs[k*CW +: CW], pix[(2-k)*PW +: PW]);
      off_q   <= coefs[3*CW +: CW];
      byp1_q  <= pass_val;
      mode1_q <= mode;
      // stage 2: accumulate
      acc_q   <= sum_d;
      byp2_q  <= byp1_q;
      mode2_q <= mode1_q;
      // stage 3: round, clamp or bypass
      res     <= mode2_q ? csc_round_clamp(acc_q) : byp2_q;
    end
  end
endmodule

// File: rtl/rgb2yuv_csc.sv
module rgb2yuv_csc
  import csc_pkg::*;
#(
  parameter int PW = PIX_W,
  parameter int CW = COEF_W,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [CW-1:0] reg_wdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3*PW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eol,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [3*PW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eol
);
  localparam int STAGES = 3;
  localparam int ROWS   = 3;

  logic [NUM_COEF*CW-1:0] coef_flat;
  logic conv_en_cfg, px_mode, frame_mode;
  logic adv, accept;
  logic [STAGES-1:0] vld_q, sof_q, eol_q;

  assign adv      = !vld_q[STAGES-1] || out_ready;
  assign in_ready = adv;
  assign accept   = in_valid && adv;

  csc_coef_bank #(.NCOEF(NUM_COEF), .CW(CW), .AW(AW)) u_bank (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
    .coef_flat, .conv_en_cfg
  );

  csc_frame_mode u_mode (
    .clk, .rst_n, .accept, .sof(in_sof), .en_cfg(conv_en_cfg),
    .px_mode, .frame_mode
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    csc_row #(.PW(PW), .CW(CW)) u_row (
      .clk, .rst_n, .adv,
      .pix(in_data),
      .coefs(coef_flat[4*r*CW +: 4*CW]),
      .pass_val(in_data[(ROWS-1-r)*PW +: PW]),
      .mode(px_mode),
      .res(out_data[(ROWS-1-r)*PW +: PW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      sof_q <= '0;
      eol_q <= '0;
    end else if (adv) begin
      vld_q <= {vld_q[STAGES-2:0], accept};
      sof_q <= {sof_q[STAGES-2:0], in_sof};
      eol_q <= {eol_q[STAGES-2:0], in_eol};
    end
  end

  assign out_valid = vld_q[STAGES-1];
  assign out_sof   = sof_q[STAGES-1];
  assign out_eol   = eol_q[STAGES-1];
endmodule

// File: rtl/csc_checker.sv
module csc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [23:0] in_data,
  input logic        in_sof,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_data,
  input logic        out_sof,
  input logic        out_eol,
  input logic        px_mode,
  input logic        frame_mode,
  input logic        reg_wr,
  input logic [3:0]  reg_addr,
  input logic [167:0] coef_flat,
  input logic        conv_en_cfg
);
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eol));

  assert_stall_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_latency_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready ##1 in_ready |=> out_valid);

  assert_latency_sof_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sof) ##1 in_ready ##1 in_ready |=> out_sof);

  assert_bypass_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !px_mode) ##1 in_ready ##1 in_ready |=> out_data == $past(in_data, 3));

  assert_mode_frame_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && in_sof) |=> $stable(frame_mode));

  assert_unused_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr > 4'd12 |=> $stable(coef_flat) && $stable(conv_en_cfg));
endmodule

bind rgb2yuv_csc csc_checker u_csc_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_sof(in_sof), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol),
  .px_mode(px_mode), .frame_mode(frame_mode), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .coef_flat(coef_flat), .conv_en_cfg(conv_en_cfg)
);

// File: tb/rgb2yuv_csc_test.sv
module rgb2yuv_csc_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, reg_wr, in_valid, in_ready, in_sof, in_eol;
  logic out_valid, out_ready, out_sof, out_eol;
  logic [3:0]  reg_addr;
  logic [13:0] reg_wdata;
  logic [23:0] in_data, out_data;

  rgb2yuv_csc uut (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
    .in_valid, .in_ready, .in_data, .in_sof, .in_eol,
    .out_valid, .out_ready, .out_data, .out_sof, .out_eol
  );

  int total = 0, bad = 0;
  int m_coef[12];
  bit m_en = 0, m_frame = 0;
  logic [25:0] expq[$];
  string cur_req = "R1";
  int ready_pct = 100;
  bit prev_stall = 0;
  logic [25:0] prev_out;
  bit seen_valid;

  function automatic int dflt(int i);
    int t[12] = '{263, 516, 100, 264, 16233, 16086, 449, 2056, 449, 16008, 16312, 2056};
    return t[i];
  endfunction

  function automatic int sx14(int c);
    return (c >= 8192) ? c - 16384 : c;
  endfunction

  function automatic logic [7:0] chan(int r, int g, int b, int row);
    int acc, q;
    acc = sx14(m_coef[4*row]) * r + sx14(m_coef[4*row+1]) * g
        + sx14(m_coef[4*row+2]) * b + m_coef[4*row+3] * 64;
    q = (acc + 512) >>> 10;
    if (q < 0) q = 0;
    if (q > 255) q = 255;
    return 8'(q);
  endfunction

  function automatic logic [23:0] model(logic [23:0] px, bit mode);
    int r, g, b;
    if (!mode) return px;
    r = px[23:16]; g = px[15:8]; b = px[7:0];
    return {chan(r, g, b, 0), chan(r, g, b, 1), chan(r, g, b, 2)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit rnd_ready();
    return ($urandom % 100) < ready_pct;
  endfunction

  task automatic step(bit v, logic [23:0] d, bit s, bit e, bit ordy, output bit acc);
    bit mode;
    @(negedge clk);
    in_valid = v; in_data = d; in_sof = s; in_eol = e; out_ready = ordy;
    #1;
    seen_valid = out_valid;
    if (prev_stall)
      check("R9", {6'd0, out_sof, out_eol, out_data}, {6'd0, prev_out}, "held output");
    if (out_valid && out_ready) begin
      if (expq.size() == 0)
        check("R8", 32'd1, 32'd0, "unexpected output pixel");
      else
        check(cur_req, {6'd0, out_sof, out_eol, out_data}, {6'd0, expq.pop_front()}, "output pixel");
    end
    prev_stall = out_valid && !out_ready;
    prev_out = {out_sof, out_eol, out_data};
    acc = v && in_ready;
    if (acc) begin
      mode = s ? m_en : m_frame;
      m_frame = mode;
      expq.push_back({s, e, model(d, mode)});
    end
  endtask

  task automatic send(logic [23:0] d, bit s, bit e);
    bit acc;
    do step(1'b1, d, s, e, rnd_ready(), acc); while (!acc);
  endtask

  task automatic drain();
    bit acc;
    while (expq.size() != 0) step(1'b0, 24'd0, 1'b0, 1'b0, rnd_ready(), acc);
    step(1'b0, 24'd0, 1'b0, 1'b0, 1'b1, acc);
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    in_valid = 0; out_ready = 0; reg_wr = 1;
    reg_addr = 4'(addr); reg_wdata = 14'(data);
    @(negedge clk);
    reg_wr = 0;
    prev_stall = 0;
    if (addr < 12) m_coef[addr] = data & 16'h3FFF;
    else if (addr == 12) m_en = data[0];
  endtask

  task automatic frame(int n, string req);
    bit acc;
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      if (($urandom % 4) == 0) step(1'b0, 24'd0, 1'b0, 1'b0, rnd_ready(), acc);
      send(24'($urandom), i == 0, i == n - 1);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit acc;
    int lat;
    void'($urandom(32'd4711));
    for (int i = 0; i < 12; i++) m_coef[i] = dflt(i);
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    in_valid = 0; in_data = 0; in_sof = 0; in_eol = 0; out_ready = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1", {31'd0, out_valid}, 32'd0, "out_valid after reset");
    check("R1", {31'd0, in_ready}, 32'd1, "in_ready after reset");

    // R1/R6: conversion off after reset, pass-through with random backpressure
    ready_pct = 60;
    frame(60, "R6");
    drain();

    // R1: defaults, enable via address 12 bit 0
    wr(12, 1);
    cur_req = "R1";
    send(24'hFFFFFF, 1, 0); send(24'h000000, 0, 0);
    send(24'hFF0000, 0, 0); send(24'h00FF00, 0, 0); send(24'h0000FF, 0, 1);
    frame(80, "R1");
    drain();

    // R8: latency of three cycles on an idle pipeline
    ready_pct = 100;
    cur_req = "R8";
    step(1'b1, 24'h123456, 1'b1, 1'b1, 1'b1, acc);
    lat = 0;
    for (int j = 1; j <= 6; j++) begin
      step(1'b0, 24'd0, 1'b0, 1'b0, 1'b1, acc);
      if (seen_valid && lat == 0) lat = j;
    end
    check("R8", 32'(lat), 32'd3, "cycles to output");
    drain();

    // R2: single nonzero weight at index 1 (Y from G)
    for (int i = 0; i < 12; i++) wr(i, 0);
    wr(1, 14'h400);
    cur_req = "R2";
    send(24'h114D22, 1, 0); send(24'h00FF00, 0, 1);
    drain();

    // R5: saturate high, saturate low, tie rounds upward
    for (int i = 0; i < 3; i++) begin
      wr(i, 14'h1FFF); wr(4 + i, 14'h2000); wr(8 + i, 0);
    end
    wr(8, 14'h400); wr(11, 8); wr(3, 0); wr(7, 0);
    cur_req = "R5";
    send(24'h646464, 1, 0); send(24'hFFFFFF, 0, 0); send(24'h010101, 0, 1);
    frame(30, "R5");
    drain();

    // R4: offsets only
    for (int i = 0; i < 12; i++) wr(i, 0);
    for (int k = 0; k < 4; k++) begin
      wr(3, $urandom % 4096); wr(7, $urandom % 4096); wr(11, $urandom % 4096);
      frame(8, "R4");
      drain();
    end

    // R3: random signed weights and offsets
    ready_pct = 70;
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 12; i++) wr(i, $urandom % 16384);
      frame(40, "R3");
      drain();
    end

    // R7: enable changes mid-frame wait for the next start of frame
    for (int i = 0; i < 12; i++) wr(i, dflt(i));
    cur_req = "R7";
    send(24'($urandom), 1, 0);
    for (int i = 0; i < 4; i++) send(24'($urandom), 0, 0);
    wr(12, 0);
    for (int i = 0; i < 5; i++) send(24'($urandom), 0, 0);
    send(24'($urandom), 1, 0);
    wr(12, 1);
    for (int i = 0; i < 5; i++) send(24'($urandom), 0, i == 4);
    send(24'($urandom), 1, 0);
    for (int i = 0; i < 3; i++) send(24'($urandom), 0, 0);
    drain();

    // R10: writes above address 12 are ignored
    wr(13, 0); wr(14, 14'h3FFF); wr(15, 14'h1234);
    frame(40, "R10");
    drain();

    check("R8", 32'(expq.size()), 32'd0, "pixels left in flight");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule